// File: doc/BRIEF.md
# Radix-4 Booth Wallace Multiplier

This block multiplies two signed two's-complement operands of N bits each and returns the full 2N-bit product. It is meant to be the arithmetic core of one processing element in a systolic matrix-multiply array.

The multiplier operand is recoded into radix-4 digits in the range -2 to +2, so there is one partial product for every two operand bits. Each partial product is the multiplicand times 0, ±1 or ±2, shifted to the weight of its digit. A negative multiple is built as the inverted positive multiple plus a separate 1 at the digit's weight. These single bits are gathered into one extra row. All rows are sign-extended to 2N bits. A Wallace tree of 3:2 carry-save adders reduces them to a sum row and a carry row. A grouped carry-lookahead adder then adds those two rows.

Operands are captured in one register stage when `in_valid` is high. The product and `out_valid` appear one clock after the operands are presented. The parameter N must be even and at least 4.

Top module: `booth_wallace_mul`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `out_valid` is 0 and `prod_out` is 0.
- R2: `out_valid` in each cycle equals the `in_valid` sampled at the previous rising clock edge (latency of one cycle).
- R3: After a rising edge where `in_valid` is 1, `prod_out` equals the signed product of `a_in` and `b_in` taken at that edge, as a 2N-bit two's-complement value. This holds for every operand pair.
- R4: At a rising edge where `in_valid` is 0, the operands have no effect: `prod_out` keeps its previous value and `out_valid` goes to 0.
- R5: The most negative operand is handled exactly. With N = 8, (-128)·(-128) = 16384 (0x4000), (-128)·(-1) = 128 and (-128)·127 = -16256 (0xC080).
- R6: Multiplier operands whose recoded digits are all ±1, ±2 or negative zero give the exact product. With N = 8, 85·(-86) = -7310 (0xE372), 2·(-2) = -4 (0xFFFC) and (-1)·(-1) = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands on `a_in`/`b_in` are valid and are captured |
| a_in | input | N | Signed multiplicand |
| b_in | input | N | Signed multiplier (Booth-recoded) |
| out_valid | output | 1 | `prod_out` holds a new product |
| prod_out | output | 2N | Signed 2N-bit product |

## Verification
The bench goes after the most negative operand, both alone and squared. A design that truncates sign extension or drops the top partial product's sign would return a negated or wrapped value for these. It also uses multiplier patterns that produce only ±2 digits, or digits that are negative zero (all-ones triplets). A wrong two-times select or a missing +1 correction bit would be off by the multiplicand or by a power of four. An exhaustive sweep of all 65536 pairs at N = 8 catches a carry lost in the tree or in the lookahead groups, because such an error shows up only for some bit patterns. Idle cycles with changing operands show whether the capture register ignores them or leaks them into the product.

// File: rtl/booth_mul_pkg.sv
package booth_mul_pkg;

   typedef struct packed {
      logic neg;
      logic one;
      logic two;
   } booth_dig_t;

   function automatic int csa_rows_next(input int r);
      return (r / 3) * 2 + (r % 3);
   endfunction

   function automatic int csa_rows_at(input int r, input int lvl);
      int n;
      n = r;
      for (int i = 0; i < lvl; i++) n = csa_rows_next(n);
      return n;
   endfunction

   function automatic int csa_depth(input int r);
      int n;
      int d;
      n = r;
      d = 0;
      for (int i = 0; i < 64; i++) begin
         if (n > 2) begin
            n = csa_rows_next(n);
            d = d + 1;
         end
      end
      return d;
   endfunction

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
   import booth_mul_pkg::*;
#(
   parameter int N  = 8,
   localparam int ND = N / 2
) (
   input  logic [N-1:0] mplr,
   output booth_dig_t   digs [ND]
);
   logic [N:0] ext;
   assign ext = {mplr, 1'b0};

   for (genvar i = 0; i < ND; i++) begin : g_dig
      logic [2:0] trip;
      assign trip         = ext[2*i+2 -: 3];
      assign digs[i].neg  = trip[2];
      assign digs[i].one  = trip[1] ^ trip[0];
      assign digs[i].two  = (trip[2] & ~trip[1] & ~trip[0]) |
                            (~trip[2] & trip[1] & trip[0]);
   end
endmodule

// File: rtl/pp_gen.sv
module pp_gen
   import booth_mul_pkg::*;
#(
   parameter int N  = 8,
   localparam int ND = N / 2,
   localparam int W  = 2 * N
) (
   input  logic [N-1:0] mcand,
   input  booth_dig_t   digs [ND],
   output logic [W-1:0] rows [ND+1]
);
   logic [W-1:0] sx;
   logic [W-1:0] corr;
   assign sx = {{N{mcand[N-1]}}, mcand};

   for (genvar i = 0; i < ND; i++) begin : g_pp
      logic [W-1:0] mag;
      logic [W-1:0] sgn;
      always_comb begin
         if (digs[i].one)      mag = sx;
         else if (digs[i].two) mag = {sx[W-2:0], 1'b0};
         else                  mag = '0;
      end
      assign sgn      = digs[i].neg ? ~mag : mag;
      assign rows[i]  = sgn << (2 * i);
      assign corr[2*i]   = digs[i].neg;
      assign corr[2*i+1] = 1'b0;
   end

   if (W > 2 * ND) begin : g_corr_hi
      assign corr[W-1:2*ND] = '0;
   end

   assign rows[ND] = corr;
endmodule

// File: rtl/csa_tree.sv
module csa_tree
   import booth_mul_pkg::*;
#(
   parameter int W = 16,
   parameter int R = 5,
   localparam int D = csa_depth(R)
) (
   input  logic [W-1:0] rows_in [R],
   output logic [W-1:0] sum_row,
   output logic [W-1:0] carry_row
);
   if (R < 3) begin : g_bad
      $error("csa_tree needs at least three rows");
   end

   for (genvar l = 0; l < D; l++) begin : g_lvl
      localparam int RI = csa_rows_at(R, l);
      localparam int RO = csa_rows_at(R, l + 1);
      localparam int NG = RI / 3;
      logic [W-1:0] cur [RI];
      logic [W-1:0] nxt [RO];

      if (l == 0) begin : g_src0
         assign cur = rows_in;
      end else begin : g_srcn
         assign cur = g_lvl[l-1].nxt;
      end

      for (genvar g = 0; g < NG; g++) begin : g_csa
         logic [W-1:0] x, y, z;
         logic [W-2:0] maj;
         assign x   = cur[3*g];
         assign y   = cur[3*g+1];
         assign z   = cur[3*g+2];
         assign maj = (x[W-2:0] & y[W-2:0]) | (x[W-2:0] & z[W-2:0]) |
                      (y[W-2:0] & z[W-2:0]);
         assign nxt[2*g]   = x ^ y ^ z;
         assign nxt[2*g+1] = {maj, 1'b0};
      end

      for (genvar k = 0; k < RI % 3; k++) begin : g_pass
         assign nxt[2*NG+k] = cur[3*NG+k];
      end
   end

   assign sum_row   = g_lvl[D-1].nxt[0];
   assign carry_row = g_lvl[D-1].nxt[1];
endmodule

// File: rtl/cla_adder.sv
module cla_adder #(
   parameter int W   = 16,
   parameter int GRP = 4,
   localparam int NGRP = W / GRP
) (
   input  logic [W-1:0] op_x,
   input  logic [W-1:0] op_y,
   output logic [W-1:0] sum
);
   if (W % GRP != 0) begin : g_bad
      $error("cla_adder width must be a multiple of the group size");
   end

   logic [W-1:0] gen, prp;
   logic [W:0]   cy;

   assign gen = op_x & op_y;
   assign prp = op_x ^ op_y;

   always_comb begin
      cy    = '0;
      cy[0] = 1'b0;
      for (int q = 0; q < NGRP; q++) begin
         for (int k = 0; k < GRP; k++) begin
            logic acc;
            logic chain;
            chain = 1'b1;
            for (int j = 0; j <= k; j++) chain = chain & prp[q*GRP+j];
            acc = chain & cy[q*GRP];
            for (int j = 0; j <= k; j++) begin
               logic t;
               t = gen[q*GRP+j];
               for (int m = j + 1; m <= k; m++) t = t & prp[q*GRP+m];
               acc = acc | t;
            end
            cy[q*GRP+k+1] = acc;
         end
      end
   end

   assign sum = prp ^ cy[W-1:0];
endmodule

// File: rtl/booth_wallace_mul.sv
module booth_wallace_mul
   import booth_mul_pkg::*;
#(
   parameter int N   = 8,
   parameter int GRP = 4,
   localparam int ND = N / 2,
   localparam int W  = 2 * N
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           in_valid,
   input  logic [N-1:0]   a_in,
   input  logic [N-1:0]   b_in,
   output logic           out_valid,
   output logic [2*N-1:0] prod_out
);
   if (N < 4 || (N % 2) != 0) begin : g_bad_n
      $error("booth_wallace_mul: N must be even and at least 4");
   end

   logic [N-1:0] a_q, b_q;
   logic         v_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q <= '0;
         b_q <= '0;
         v_q <= 1'b0;
      end else begin
         v_q <= in_valid;
         if (in_valid) begin
            a_q <= a_in;
            b_q <= b_in;
         end
      end
   end

   booth_dig_t   digs [ND];
   logic [W-1:0] rows [ND+1];
   logic [W-1:0] s_row, c_row;

   booth_recoder #(.N(N)) u_rec (
      .mplr (b_q),
      .digs (digs)
   );

   pp_gen #(.N(N)) u_pp (
      .mcand (a_q),
      .digs  (digs),
      .rows  (rows)
   );

   csa_tree #(.W(W), .R(ND + 1)) u_tree (
      .rows_in   (rows),
      .sum_row   (s_row),
      .carry_row (c_row)
   );

   cla_adder #(.W(W), .GRP(GRP)) u_cla (
      .op_x (s_row),
      .op_y (c_row),
      .sum  (prod_out)
   );

   assign out_valid = v_q;
endmodule

// File: rtl/booth_wallace_mul_chk.sv
module booth_wallace_mul_chk #(
   parameter int N = 8
) (
   input logic           clk,
   input logic           rst_n,
   input logic           in_valid,
   input logic [N-1:0]   a_in,
   input logic [N-1:0]   b_in,
   input logic           out_valid,
   input logic [2*N-1:0] prod_out
);
   logic [2*N-1:0] ref_p;
   assign ref_p = {{N{a_in[N-1]}}, a_in} * {{N{b_in[N-1]}}, b_in};

   // R1
   p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!out_valid && prod_out == '0));

   // R2
   p_valid_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R3, also covers the R5 and R6 operand patterns
   p_prod_ok_r3: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (prod_out == $past(ref_p)));

   // R4
   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(prod_out));

   // R4
   p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
endmodule

bind booth_wallace_mul booth_wallace_mul_chk #(.N(N)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .a_in      (a_in),
   .b_in      (b_in),
   .out_valid (out_valid),
   .prod_out  (prod_out)
);

// File: tb/test_booth_wallace_mul.sv
module test_booth_wallace_mul;
   localparam int N = 8;
   localparam int W = 2 * N;
   localparam int NV = 12;

   // {a, b, expected product}
   localparam logic [31:0] VEC [NV] = '{
      {8'h7F, 8'h7F, 16'h3F01},   // R3 127*127
      {8'h80, 8'h80, 16'h4000},   // R5 -128*-128
      {8'h80, 8'h7F, 16'hC080},   // R5 -128*127
      {8'h80, 8'hFF, 16'h0080},   // R5 -128*-1
      {8'hFF, 8'hFF, 16'h0001},   // R6 -1*-1
      {8'h00, 8'h80, 16'h0000},   // R3 0*-128
      {8'h02, 8'hFE, 16'hFFFC},   // R6 2*-2
      {8'h55, 8'hAA, 16'hE372},   // R6 85*-86
      {8'hAA, 8'h55, 16'hE372},   // R6 -86*85
      {8'h01, 8'h80, 16'hFF80},   // R5 1*-128
      {8'h64, 8'h03, 16'h012C},   // R3 100*3
      {8'hF9, 8'h0D, 16'hFFA5}    // R3 -7*13
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [N-1:0] a_in = '0;
   logic [N-1:0] b_in = '0;
   logic         out_valid;
   logic [W-1:0] prod_out;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   booth_wallace_mul #(.N(N)) i_booth_wallace_mul (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .a_in      (a_in),
      .b_in      (b_in),
      .out_valid (out_valid),
      .prod_out  (prod_out)
   );

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [W-1:0] ref_mul(input logic [N-1:0] a, input logic [N-1:0] b);
      logic signed [W-1:0] sa, sb;
      sa = W'($signed(a));
      sb = W'($signed(b));
      return W'(sa * sb);
   endfunction

   initial begin
      logic [W-1:0] last_exp;
      repeat (3) @(negedge clk);
      chk("R1 valid in reset", W'(out_valid), '0);
      chk("R1 product in reset", prod_out, '0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 valid after release", W'(out_valid), '0);
      chk("R1 product after release", prod_out, '0);

      // table walk
      last_exp = '0;
      for (int i = 0; i <= NV; i++) begin
         @(negedge clk);
         if (i > 0) begin
            chk("R2 valid one cycle later", W'(out_valid), 1);
            chk("R3/R5/R6 table product", prod_out, last_exp);
         end
         if (i < NV) begin
            in_valid = 1'b1;
            a_in     = VEC[i][31:24];
            b_in     = VEC[i][23:16];
            last_exp = VEC[i][15:0];
         end else begin
            in_valid = 1'b0;
            a_in     = 8'h33;
            b_in     = 8'h44;
         end
      end

      // R4: operands ignored while in_valid is low
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk("R4 product held while idle", prod_out, last_exp);
         chk("R4 valid low while idle", W'(out_valid), '0);
         a_in = a_in + 8'h11;
         b_in = b_in - 8'h07;
      end

      // R3: exhaustive sweep, pipelined
      for (int ai = 0; ai < 256; ai++) begin
         for (int bi = 0; bi < 256; bi++) begin
            @(negedge clk);
            if (ai != 0 || bi != 0) chk("R3 exhaustive product", prod_out, last_exp);
            in_valid = 1'b1;
            a_in     = N'(ai);
            b_in     = N'(bi);
            last_exp = ref_mul(N'(ai), N'(bi));
         end
      end
      @(negedge clk);
      chk("R3 exhaustive last product", prod_out, last_exp);
      chk("R2 valid after sweep", W'(out_valid), 1);

      // R1: reset in mid-stream
      in_valid = 1'b1;
      a_in = 8'h7F;
      b_in = 8'h80;
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R1 valid cleared by reset", W'(out_valid), '0);
      chk("R1 product cleared by reset", prod_out, '0);
      @(negedge clk);
      in_valid = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 valid stays low after reset", W'(out_valid), '0);
      chk("R1 product stays zero after reset", prod_out, '0);

      done = 1'b1;
   end

   initial begin
      int cyc;
      cyc = 0;
      while (!done && cyc < 200000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
      end
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule